// File: doc/BRIEF.md
# Vote/Split Triple-Slice Logic Tile

This tile holds three identical logic slices. Each slice has a lookup table, an output register that can be bypassed, and its own configuration register. Each configuration register is loaded serially through its own port. A single mode input sets how the three slices work together.

In split mode the tile gives three independent single-string cells. Each cell has its own inputs, its own program and its own output. In vote mode the same hardware forms one triple-redundant cell:

- Every slice reads slice A's input pins.
- All three outputs carry the bitwise majority of the slice results.
- Each slice register takes its feedback from the majority of the three registers.

With voted feedback, one corrupted register is repaired on the next clock. An upset in one slice's configuration is outvoted, and a flag reports that the slices disagree. The mode change is registered, so it takes effect at the next clock edge.

Top module: `tri_mode_tile`

## Requirements
- R1: A synchronous reset sets all of the following: configuration registers to zero, slice registers to zero, and the registered mode to split. After reset, all outputs and the mismatch flag are 0.
- R2: Each slice has its own configuration word of 2^K+1 bits (K=4 gives 17 bits). While that slice's shift enable is high, each clock moves the word up one bit and loads the serial input into bit 0. After 2^K+1 shifts, the first bit sent sits in the top bit, which is the register-select bit. Bits 2^K-1..0 form the table, and entry n is the result for LUT address n, with address bit 0 as the LSB. While the shift enable is low, the word holds its value.
- R3: In split mode (registered mode 0), output s equals the result of slice s. Slice s reads pins slice_pins[s*K +: K].
- R4: In vote mode (registered mode 1), every output equals the bitwise majority (a&b)|(b&c)|(a&c) of the three slice results.
- R5: In vote mode, all three slices read slice A's pins, slice_pins[K-1:0]. The pins of slices B and C have no effect on any output.
- R6: When the register-select bit is 1, the slice result is the slice register. That register loads the LUT output on every clock. LUT address bit K-1 is then the register feedback in place of pin K-1. When the select bit is 0, the result is the LUT output for the pins, and the register still loads each clock.
- R7: The register feedback is the slice's own register in split mode. In vote mode it is the majority of the three registers. As a result, when all slices hold the same configuration, registers that differ become equal after one clock in vote mode.
- R8: The mismatch flag is 1 exactly when the tile is in vote mode and the three slice results are not all equal. It is 0 in split mode.
- R9: The mode input is registered. A change on it alters the outputs only after the next rising clock edge.
- R10: A configuration shift on one slice changes the result of that slice only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_vote | input | 1 | 1 = vote mode, 0 = split mode (registered) |
| slice_pins | input | 3*K | LUT input pins; slice s uses bits s*K +: K |
| cfg_sdi | input | 3 | Serial configuration data, one bit per slice |
| cfg_shift | input | 3 | Configuration shift enable, one bit per slice |
| tile_out | output | 3 | Tile outputs, one per slice |
| mismatch | output | 1 | Slice results disagree in vote mode |

## Verification
The assertions check the following on every cycle:
- Outputs agree in vote mode and pass through in split mode.
- The mismatch flag is quiet in split mode.
- The registered mode lags its input by one clock.
- A configuration word holds while its shift enable is low, and its shift-in bit lands correctly.
- Each slice register captures the previous LUT output.

Only the bench scenarios can show the rest. Register repair after a mode change from a desynchronised split state depends on a chosen history. Ignoring the B and C pins in vote mode needs deliberately different pin values. Isolating one slice's configuration load from its neighbours needs a comparison against an independent model across whole load sequences.

// File: rtl/tile_pkg.sv
package tile_pkg;

   localparam int unsigned SLICES = 3;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (b & c) | (a & c);
   endfunction

   function automatic logic all_equal3(input logic a, input logic b, input logic c);
      return (a == b) && (b == c);
   endfunction

endpackage

// File: rtl/tile_cfg_shift.sv
module tile_cfg_shift #(
   parameter int unsigned K = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shift_en,
   input  logic              sdi,
   output logic [(1<<K)-1:0] lut_tbl,
   output logic              reg_sel
);
   localparam int unsigned TBL = 1 << K;
   localparam int unsigned W   = TBL + 1;

   logic [W-1:0] cfg;

   always_ff @(posedge clk) begin
      if (rst)           cfg <= '0;
      else if (shift_en) cfg <= {cfg[W-2:0], sdi};
   end

   assign lut_tbl = cfg[TBL-1:0];
   assign reg_sel = cfg[W-1];

   // R2: word holds while the shift enable is low
   a_r2_cfg_hold: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(shift_en)) |-> $stable(cfg));

   // R2: serial bit lands in bit 0
   a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(shift_en)) |-> (cfg[0] == $past(sdi)));

endmodule

// File: rtl/tile_lut.sv
module tile_lut #(
   parameter int unsigned K = 4
) (
   input  logic [(1<<K)-1:0] tbl,
   input  logic [K-1:0]      addr,
   output logic              y
);
   assign y = tbl[addr];
endmodule

// File: rtl/tile_slice.sv
module tile_slice #(
   parameter int unsigned K = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         cfg_shift,
   input  logic         cfg_sdi,
   input  logic [K-1:0] pins,
   input  logic         use_vote,
   input  logic         fb_voted,
   output logic         q,
   output logic         res
);
   localparam int unsigned TBL = 1 << K;

   logic [TBL-1:0] tbl;
   logic           reg_sel;
   logic           fb;
   logic [K-1:0]   addr;
   logic           lut_y;

   tile_cfg_shift #(.K(K)) u_cfg (
      .clk(clk), .rst(rst), .shift_en(cfg_shift), .sdi(cfg_sdi),
      .lut_tbl(tbl), .reg_sel(reg_sel)
   );

   assign fb   = use_vote ? fb_voted : q;
   assign addr = reg_sel ? {fb, pins[K-2:0]} : pins;

   tile_lut #(.K(K)) u_lut (.tbl(tbl), .addr(addr), .y(lut_y));

   always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= lut_y;
   end

   assign res = reg_sel ? q : lut_y;

   // R6: register holds the previous LUT output
   a_r6_reg_capture: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (q == $past(lut_y)));

endmodule

// File: rtl/tile_voter.sv
module tile_voter (
   input  logic       vote,
   input  logic [2:0] res,
   output logic [2:0] out,
   output logic       mismatch
);
   import tile_pkg::*;

   logic m;
   assign m = maj3(res[0], res[1], res[2]);

   for (genvar s = 0; s < 3; s++) begin : g_out
      assign out[s] = vote ? m : res[s];
   end

   assign mismatch = vote && !all_equal3(res[0], res[1], res[2]);
endmodule

// File: rtl/tri_mode_tile.sv
module tri_mode_tile #(
   parameter int unsigned K = 4
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           mode_vote,
   input  logic [3*K-1:0] slice_pins,
   input  logic [2:0]     cfg_sdi,
   input  logic [2:0]     cfg_shift,
   output logic [2:0]     tile_out,
   output logic           mismatch
);
   import tile_pkg::*;

   if (K < 2 || K > 6) begin : g_bad_k
      $error("tri_mode_tile: K must lie in 2..6");
   end

   logic       mode_q;
   logic [2:0] q;
   logic [2:0] res;
   logic       fb_voted;

   always_ff @(posedge clk) begin
      if (rst) mode_q <= 1'b0;
      else     mode_q <= mode_vote;
   end

   assign fb_voted = maj3(q[0], q[1], q[2]);

   for (genvar s = 0; s < SLICES; s++) begin : g_slice
      logic [K-1:0] pins_s;
      assign pins_s = mode_q ? slice_pins[K-1:0] : slice_pins[s*K +: K];

      tile_slice #(.K(K)) u_slice (
         .clk(clk), .rst(rst),
         .cfg_shift(cfg_shift[s]), .cfg_sdi(cfg_sdi[s]),
         .pins(pins_s), .use_vote(mode_q), .fb_voted(fb_voted),
         .q(q[s]), .res(res[s])
      );
   end

   tile_voter u_voter (.vote(mode_q), .res(res), .out(tile_out), .mismatch(mismatch));

   // R4: outputs agree in vote mode
   a_r4_outputs_agree: assert property (@(posedge clk) disable iff (rst)
      mode_q |-> (tile_out[0] == tile_out[1] && tile_out[1] == tile_out[2]));

   // R3: split mode passes slice results through
   a_r3_split_pass: assert property (@(posedge clk) disable iff (rst)
      !mode_q |-> (tile_out == res));

   // R8: flag quiet in split mode
   a_r8_split_quiet: assert property (@(posedge clk) disable iff (rst)
      !mode_q |-> !mismatch);

   // R9: mode follows its input one clock later
   a_r9_mode_lag: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (mode_q == $past(mode_vote)));

endmodule

// File: tb/tri_mode_tile_bench.sv
module tri_mode_tile_bench;
   localparam int K = 4;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         mode_vote = 1'b0;
   logic [11:0]  slice_pins = '0;
   logic [2:0]   cfg_sdi = '0;
   logic [2:0]   cfg_shift = '0;
   logic [2:0]   tile_out;
   logic         mismatch;

   int n_chk = 0;
   int n_fail = 0;
   bit chk_on = 0;
   string cur_req = "R1";

   // reference model state
   bit [16:0] m_cfg [3];
   bit        m_q   [3];
   bit        m_mode;

   always #2 clk = ~clk;

   tri_mode_tile #(.K(K)) u_tri_mode_tile (
      .clk(clk), .rst(rst), .mode_vote(mode_vote), .slice_pins(slice_pins),
      .cfg_sdi(cfg_sdi), .cfg_shift(cfg_shift), .tile_out(tile_out), .mismatch(mismatch)
   );

   function automatic bit mj(bit a, bit b, bit c);
      return (a & b) | (b & c) | (a & c);
   endfunction

   function automatic bit m_lut(int s);
      bit [3:0] p;
      bit fb;
      int idx;
      p = m_mode ? slice_pins[3:0] : slice_pins[s*4 +: 4];
      fb = m_mode ? mj(m_q[0], m_q[1], m_q[2]) : m_q[s];
      if (m_cfg[s][16]) idx = {fb, p[2:0]};
      else              idx = p;
      return m_cfg[s][idx];
   endfunction

   function automatic bit m_res(int s);
      return m_cfg[s][16] ? m_q[s] : m_lut(s);
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < 3; s++) begin m_cfg[s] = '0; m_q[s] = 0; end
         m_mode = 0;
      end else begin
         bit nq [3];
         for (int s = 0; s < 3; s++) nq[s] = m_lut(s);
         for (int s = 0; s < 3; s++) begin
            m_q[s] = nq[s];
            if (cfg_shift[s]) m_cfg[s] = {m_cfg[s][15:0], cfg_sdi[s]};
         end
         m_mode = mode_vote;
      end
   end

   task automatic check_now();
      bit r [3];
      bit [2:0] eo;
      bit em;
      for (int s = 0; s < 3; s++) r[s] = m_res(s);
      for (int s = 0; s < 3; s++) eo[s] = m_mode ? mj(r[0], r[1], r[2]) : r[s];
      em = m_mode && !(r[0] == r[1] && r[1] == r[2]);
      n_chk++;
      if (tile_out !== eo || mismatch !== em) begin
         n_fail++;
         $display("FAIL %s: out=%b mis=%b expected out=%b mis=%b", cur_req, tile_out, mismatch, eo, em);
      end
   endtask

   // inputs set right after a falling edge; check 1 ns later, before the rising edge
   task automatic cyc();
      #1;
      if (chk_on) check_now();
      @(negedge clk);
   endtask

   // R2: send the top bit first
   task automatic load_cfg(int s, bit [16:0] w);
      for (int i = 16; i >= 0; i--) begin
         cfg_shift = 3'b000; cfg_sdi = 3'b000;
         cfg_shift[s] = 1'b1; cfg_sdi[s] = w[i];
         cyc();
      end
      cfg_shift = 3'b000; cfg_sdi = 3'b000;
   endtask

   task automatic sweep_pins(int n, int seed);
      for (int i = 0; i < n; i++) begin
         slice_pins = 12'((i * 12'h359 + seed * 12'h1a7) ^ (i << 5));
         cyc();
      end
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      @(negedge clk);
      cyc(); cyc();
      chk_on = 1;
      cur_req = "R1"; cyc(); cyc();             // reset state
      rst = 0;
      cur_req = "R1"; cyc();                    // zero config after reset

      // R2 / R10: load each slice; the others must stay unaffected
      cur_req = "R2_R10";
      load_cfg(0, {1'b0, 16'h8000});            // AND4
      load_cfg(1, {1'b0, 16'h6996});            // XOR4
      load_cfg(2, {1'b0, 16'hFFFE});            // OR4
      cur_req = "R2_hold"; sweep_pins(6, 1);    // shift disabled: hold

      cur_req = "R3";    sweep_pins(20, 2);     // split, own pins
      slice_pins = 12'hFFF; cyc();
      slice_pins = 12'h0F0; cyc();

      // R9: mode change lands after the next edge
      mode_vote = 1; slice_pins = 12'h00F;
      cur_req = "R9"; cyc(); cyc();
      cur_req = "R4_R8"; sweep_pins(20, 3);
      // R5: vary only B and C pins with A fixed
      cur_req = "R5";
      for (int i = 0; i < 16; i++) begin
         slice_pins = {4'(i), 4'(15 - i), 4'h5};
         cyc();
      end
      mode_vote = 0; cur_req = "R9"; cyc(); cyc();

      // R6 / R7: registered toggle config next = fb ^ pin0
      cur_req = "R6";
      load_cfg(0, 17'h155AA);
      load_cfg(1, 17'h155AA);
      load_cfg(2, 17'h155AA);
      slice_pins = 12'h001; cyc(); cyc();       // only slice A toggles
      slice_pins = 12'h010; cyc(); cyc(); cyc(); // only slice B toggles
      slice_pins = 12'h000; cyc();
      cur_req = "R7"; mode_vote = 1;
      cyc(); cyc();                             // registers repaired
      slice_pins = 12'h001; cyc(); cyc(); cyc();
      slice_pins = 12'h110; cyc(); cyc();       // B/C pins ignored
      // R10: upset slice C config while voting; outvoted, flag raised
      cur_req = "R10";
      load_cfg(2, {1'b0, 16'h0000});
      sweep_pins(8, 5);
      mode_vote = 0; cur_req = "R3"; sweep_pins(8, 6);

      // R1: reset again mid-run
      rst = 1; cur_req = "R1"; cyc(); cyc();
      rst = 0; cyc();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule